// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block carries 16-bit words in both directions between a main host processor and an audio coprocessor. Each direction owns a single-word latch and a full flag: the host drops a command word that the coprocessor picks up, and the coprocessor posts a reply word that the host collects. Reading a word empties its latch. The coprocessor sees a level command interrupt while a command is waiting. The host sees a two-bit vector of interrupt reasons and a registered interrupt line.

A two-bit host control register does two jobs. Its value gates which interrupt reasons reach the host. When the value is zero, it holds the coprocessor in reset. While that reset is held, both full flags stay cleared, and the block drops writes from either side. Both sides can read the two flags in a fixed status layout: the host through its control readback, and the coprocessor through a status word and a flag word.

Top module: `cmd_mailbox`

## Requirements
- R1: When the coprocessor is not held in reset, a host write (`h_wr_en`) stores `h_wr_data` in the command latch at the next clock edge. After that edge, `c_cmd_data` shows the word, the command flag is set and `c_cmd_irq` is high.
- R2: `c_cmd_irq` is a level that stays high until the coprocessor strobes `c_cmd_rd_en`. The strobe cycle sees the stored word on `c_cmd_data`, and the command flag and `c_cmd_irq` clear at the following edge.
- R3: When the coprocessor is not held in reset, a reply write (`c_rep_wr_en`) stores `c_rep_wr_data` in the reply latch and sets the reply flag. A host read (`h_rd_en`) sees the word on `h_rd_data` and clears the reply flag. If a load and a read of the same latch fall in one cycle, the load wins: the new word is kept and the flag stays set.
- R4: Reason bit 0 (`h_irq_reason[0]`, buffer empty) is high exactly when the control value is 2'b11 and the command flag is clear.
- R5: Reason bit 1 (`h_irq_reason[1]`, reply ready) is high exactly when control bit 1 is set and the reply flag is set.
- R6: Control value 2'b00, which is also the value after reset, drives `c_reset` high. At the same edge that loads 2'b00, both flags clear. While that value is held, host writes and reply writes are dropped: neither the latches nor the flags change. Any other control value releases `c_reset`.
- R7: `h_ctl_rd` returns the command flag at bit 1 and the reply flag at bit 0.
- R8: `c_status` returns the command flag at bit 7 and the inverse of the reply flag at bit 6. Its other bits are zero.
- R9: `c_flags` returns the command flag at bit 3 and the reply flag at bit 7. Its other bits are zero.
- R10: `h_irq` equals the OR of the two reason bits delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr_en | input | 1 | Host command write strobe |
| h_wr_data | input | 16 | Host command word |
| h_rd_en | input | 1 | Host reply read strobe |
| h_rd_data | output | 16 | Reply latch contents |
| h_ctl_wr_en | input | 1 | Host control register write strobe |
| h_ctl_wr_data | input | 2 | New control value |
| h_ctl_rd | output | 2 | Flag readback: bit 1 command, bit 0 reply |
| h_irq_reason | output | 2 | Bit 0 buffer empty, bit 1 reply ready |
| h_irq | output | 1 | Registered OR of the reasons |
| c_cmd_rd_en | input | 1 | Coprocessor command read strobe |
| c_cmd_data | output | 16 | Command latch contents |
| c_rep_wr_en | input | 1 | Coprocessor reply write strobe |
| c_rep_wr_data | input | 16 | Reply word |
| c_status | output | 8 | Bit 7 command flag, bit 6 reply flag inverted |
| c_flags | output | 8 | Bit 3 command flag, bit 7 reply flag |
| c_cmd_irq | output | 1 | Command waiting interrupt level |
| c_reset | output | 1 | Coprocessor held in reset |

## Verification
The transfer paths run with several distinct words in each direction. A word that is seen twice or arrives late shows up as a miscompare in the queue. Each control value is applied with each flag both set and clear. This separates the full-value gate of the empty reason from the single-bit gate of the ready reason, and shows that values 01 and 10 both release reset. Simultaneous load and read on one latch separates load-wins priority from clear-wins priority. Writes issued while reset is held, and a reset entered with both flags set, show that the hold both clears the flags and drops incoming data.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  localparam int CTL_W        = 2;
  localparam int STAT_W       = 8;
  localparam int RSN_W        = 2;
  localparam int RSN_EMPTY    = 0;
  localparam int RSN_READY    = 1;
  localparam int ST_CMD_BIT   = 7;
  localparam int ST_RNE_BIT   = 6;
  localparam int FL_CMD_BIT   = 3;
  localparam int FL_REP_BIT   = 7;
  localparam int CTLRD_CMD    = 1;
  localparam int CTLRD_REP    = 0;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              full
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, full_d;
  logic              data_en;

  always_comb begin
    data_en = load && !hold;
    full_d  = full_q;
    if (hold)         full_d = 1'b0;
    else if (load)    full_d = 1'b1;
    else if (take)    full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (data_en) data_q <= load_data;
      full_q <= full_d;
    end
  end

  assign data = data_q;
  assign full = full_q;
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import cmd_mailbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             cmd_full,
  input  logic             rep_full,
  output logic             hold_next,
  output logic             cpu_reset,
  output logic [RSN_W-1:0] reason,
  output logic             irq
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             irq_q, irq_d;

  always_comb begin
    ctl_d             = ctl_wr ? ctl_wr_data : ctl_q;
    hold_next         = (ctl_d == '0);
    cpu_reset         = (ctl_q == '0);
    reason            = '0;
    reason[RSN_EMPTY] = (ctl_q == {CTL_W{1'b1}}) && !cmd_full;
    reason[RSN_READY] = ctl_q[1] && rep_full;
    irq_d             = |reason;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic [DATA_W-1:0] h_wr_data,
  input  logic              h_rd_en,
  output logic [DATA_W-1:0] h_rd_data,
  input  logic              h_ctl_wr_en,
  input  logic [CTL_W-1:0]  h_ctl_wr_data,
  output logic [CTL_W-1:0]  h_ctl_rd,
  output logic [RSN_W-1:0]  h_irq_reason,
  output logic              h_irq,
  input  logic              c_cmd_rd_en,
  output logic [DATA_W-1:0] c_cmd_data,
  input  logic              c_rep_wr_en,
  input  logic [DATA_W-1:0] c_rep_wr_data,
  output logic [STAT_W-1:0] c_status,
  output logic [STAT_W-1:0] c_flags,
  output logic              c_cmd_irq,
  output logic              c_reset
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;
  logic                   hold_next;
  logic                   cmd_full, rep_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  mbx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ctl_wr      (h_ctl_wr_en),
    .ctl_wr_data (h_ctl_wr_data),
    .cmd_full    (cmd_full),
    .rep_full    (rep_full),
    .hold_next   (hold_next),
    .cpu_reset   (c_reset),
    .reason      (h_irq_reason),
    .irq         (h_irq)
  );

  mbx_slot #(.DATA_W(DATA_W)) u_cmd_slot (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hold      (hold_next),
    .load      (h_wr_en),
    .load_data (h_wr_data),
    .take      (c_cmd_rd_en),
    .data      (c_cmd_data),
    .full      (cmd_full)
  );

  mbx_slot #(.DATA_W(DATA_W)) u_rep_slot (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hold      (hold_next),
    .load      (c_rep_wr_en),
    .load_data (c_rep_wr_data),
    .take      (h_rd_en),
    .data      (h_rd_data),
    .full      (rep_full)
  );

  always_comb begin
    h_ctl_rd             = '0;
    h_ctl_rd[CTLRD_CMD]  = cmd_full;
    h_ctl_rd[CTLRD_REP]  = rep_full;
    c_status             = '0;
    c_status[ST_CMD_BIT] = cmd_full;
    c_status[ST_RNE_BIT] = !rep_full;
    c_flags              = '0;
    c_flags[FL_CMD_BIT]  = cmd_full;
    c_flags[FL_REP_BIT]  = rep_full;
    c_cmd_irq            = cmd_full;
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              h_wr_en,
  input logic [DATA_W-1:0] h_wr_data,
  input logic [DATA_W-1:0] h_rd_data,
  input logic              h_ctl_wr_en,
  input logic [CTL_W-1:0]  h_ctl_wr_data,
  input logic [CTL_W-1:0]  h_ctl_rd,
  input logic [RSN_W-1:0]  h_irq_reason,
  input logic              h_irq,
  input logic              c_cmd_rd_en,
  input logic [DATA_W-1:0] c_cmd_data,
  input logic              c_rep_wr_en,
  input logic [DATA_W-1:0] c_rep_wr_data,
  input logic [STAT_W-1:0] c_status,
  input logic [STAT_W-1:0] c_flags,
  input logic              c_cmd_irq,
  input logic              c_reset
);
  logic stays_live;
  assign stays_live = !(h_ctl_wr_en ? (h_ctl_wr_data == '0) : c_reset);

  // R1
  cmd_load_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (h_wr_en && stays_live) |=> (c_cmd_irq && c_cmd_data == $past(h_wr_data)));

  // R2
  cmd_take_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (c_cmd_rd_en && !h_wr_en) |=> !c_cmd_irq);

  // R3
  rep_load_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (c_rep_wr_en && stays_live) |=> (h_ctl_rd[CTLRD_REP] && h_rd_data == $past(c_rep_wr_data)));

  // R4
  empty_reason_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    h_irq_reason[RSN_EMPTY] |-> (!c_reset && !c_status[ST_CMD_BIT]));

  // R5
  ready_reason_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    h_irq_reason[RSN_READY] |-> (c_flags[FL_REP_BIT] && !c_reset));

  // R6
  hold_clear_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    c_reset |-> (h_ctl_rd == '0 && !c_cmd_irq));

  // R8
  status_mirror_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (c_status[ST_CMD_BIT] == c_flags[FL_CMD_BIT]) && (c_status[ST_RNE_BIT] != c_flags[FL_REP_BIT]));

  // R10
  irq_delay_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    1'b1 |=> (h_irq == $past(|h_irq_reason)));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DATA_W(DATA_W)) u_chk (.*, .sys_rst_n(rst_n_s));

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_wr_en = 1'b0, h_rd_en = 1'b0, h_ctl_wr_en = 1'b0;
  logic [15:0] h_wr_data = '0;
  logic [1:0]  h_ctl_wr_data = '0;
  logic        c_cmd_rd_en = 1'b0, c_rep_wr_en = 1'b0;
  logic [15:0] c_rep_wr_data = '0;
  logic [15:0] h_rd_data, c_cmd_data;
  logic [1:0]  h_ctl_rd, h_irq_reason;
  logic        h_irq, c_cmd_irq, c_reset;
  logic [7:0]  c_status, c_flags;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 0;
  logic [15:0] cmd_q[$];
  logic [15:0] rep_q[$];

  always #10 clk = ~clk;

  cmd_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr_en(h_wr_en), .h_wr_data(h_wr_data),
    .h_rd_en(h_rd_en), .h_rd_data(h_rd_data),
    .h_ctl_wr_en(h_ctl_wr_en), .h_ctl_wr_data(h_ctl_wr_data),
    .h_ctl_rd(h_ctl_rd), .h_irq_reason(h_irq_reason), .h_irq(h_irq),
    .c_cmd_rd_en(c_cmd_rd_en), .c_cmd_data(c_cmd_data),
    .c_rep_wr_en(c_rep_wr_en), .c_rep_wr_data(c_rep_wr_data),
    .c_status(c_status), .c_flags(c_flags),
    .c_cmd_irq(c_cmd_irq), .c_reset(c_reset)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(logic [1:0] v);
    h_ctl_wr_en = 1'b1; h_ctl_wr_data = v;
    @(negedge clk);
    h_ctl_wr_en = 1'b0;
  endtask

  // driver: pushes the word it expects the coprocessor to receive
  task automatic host_write(logic [15:0] d, bit accepted);
    h_wr_en = 1'b1; h_wr_data = d;
    if (accepted) begin cmd_q.delete(); cmd_q.push_back(d); end
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic cop_reply(logic [15:0] d, bit accepted);
    c_rep_wr_en = 1'b1; c_rep_wr_data = d;
    if (accepted) begin rep_q.delete(); rep_q.push_back(d); end
    @(negedge clk);
    c_rep_wr_en = 1'b0;
  endtask

  // monitor side: pops the expected word and compares
  task automatic cop_read(string req);
    logic [15:0] e;
    e = (cmd_q.size() > 0) ? cmd_q.pop_front() : 16'hxxxx;
    c_cmd_rd_en = 1'b1;
    chk(req, c_cmd_data, e);
    @(negedge clk);
    c_cmd_rd_en = 1'b0;
  endtask

  task automatic host_read(string req);
    logic [15:0] e;
    e = (rep_q.size() > 0) ? rep_q.pop_front() : 16'hxxxx;
    h_rd_en = 1'b1;
    chk(req, h_rd_data, e);
    @(negedge clk);
    h_rd_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscmp++; vectors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R6 default hold)
    chk("R6 reset c_reset", c_reset, 1);
    chk("R7 reset ctl_rd", h_ctl_rd, 0);
    chk("R8 reset status", c_status, 8'h40);
    chk("R9 reset flags", c_flags, 8'h00);
    chk("R4 reset reason", h_irq_reason, 0);
    chk("R10 reset irq", h_irq, 0);

    // R6: writes dropped while held
    host_write(16'hAAAA, 0);
    cop_reply(16'h5555, 0);
    chk("R6 held cmd flag", h_ctl_rd, 0);
    chk("R6 held cmd data", c_cmd_data, 16'h0000);
    chk("R6 held rep data", h_rd_data, 16'h0000);
    chk("R6 held irq", c_cmd_irq, 0);

    // release with 2'b11
    ctl_write(2'b11);
    chk("R6 release", c_reset, 0);
    chk("R4 empty reason", h_irq_reason, 2'b01);
    @(negedge clk);
    chk("R10 irq follows", h_irq, 1);

    // command path, several words
    foreach (cmd_words[i]) begin
      host_write(cmd_words[i], 1);
      chk("R1 cmd irq", c_cmd_irq, 1);
      chk("R7 cmd flag", h_ctl_rd, 2'b10);
      chk("R8 status cmd", c_status, 8'hC0);
      chk("R9 flags cmd", c_flags, 8'h08);
      chk("R4 no empty when full", h_irq_reason, 2'b00);
      repeat (2) @(negedge clk);
      chk("R2 level held", c_cmd_irq, 1);
      cop_read("R2 cmd word");
      chk("R2 irq clears", c_cmd_irq, 0);
    end

    // reply path
    foreach (rep_words[i]) begin
      cop_reply(rep_words[i], 1);
      chk("R3 rep flag", h_ctl_rd, 2'b01);
      chk("R5 ready reason", h_irq_reason, 2'b11);
      chk("R8 status rep", c_status, 8'h00);
      chk("R9 flags rep", c_flags, 8'h80);
      @(negedge clk);
      chk("R10 irq on ready", h_irq, 1);
      host_read("R3 rep word");
      chk("R3 rep clears", h_ctl_rd, 2'b00);
    end

    // gating with 2'b10 and 2'b01
    ctl_write(2'b10);
    chk("R4 gated by 10", h_irq_reason, 2'b00);
    chk("R6 10 releases", c_reset, 0);
    cop_reply(16'h0F0F, 1);
    chk("R5 ready with 10", h_irq_reason, 2'b10);
    ctl_write(2'b01);
    chk("R5 gated by 01", h_irq_reason, 2'b00);
    chk("R6 01 releases", c_reset, 0);
    @(negedge clk);
    chk("R10 irq low", h_irq, 0);
    host_read("R3 rep after gate");

    // R3 load-wins priority
    ctl_write(2'b11);
    host_write(16'h1111, 1);
    cmd_q.delete(); cmd_q.push_back(16'h2222);
    h_wr_en = 1'b1; h_wr_data = 16'h2222; c_cmd_rd_en = 1'b1;
    @(negedge clk);
    h_wr_en = 1'b0; c_cmd_rd_en = 1'b0;
    chk("R3 cmd load wins flag", c_cmd_irq, 1);
    cop_read("R3 cmd load wins data");
    cop_reply(16'h3333, 1);
    rep_q.delete(); rep_q.push_back(16'h4444);
    c_rep_wr_en = 1'b1; c_rep_wr_data = 16'h4444; h_rd_en = 1'b1;
    @(negedge clk);
    c_rep_wr_en = 1'b0; h_rd_en = 1'b0;
    chk("R3 rep load wins flag", h_ctl_rd, 2'b01);
    host_read("R3 rep load wins data");

    // R6 entering hold wipes flags
    host_write(16'h7777, 1);
    cop_reply(16'h8888, 1);
    chk("R7 both flags", h_ctl_rd, 2'b11);
    ctl_write(2'b00);
    chk("R6 hold asserted", c_reset, 1);
    chk("R6 flags wiped", h_ctl_rd, 2'b00);
    chk("R6 cmd irq wiped", c_cmd_irq, 0);
    chk("R8 status after wipe", c_status, 8'h40);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  logic [15:0] cmd_words [3] = '{16'h1234, 16'hFFFF, 16'h0001};
  logic [15:0] rep_words [3] = '{16'hBEEF, 16'h0000, 16'h8001};
endmodule